// File: doc/BRIEF.md
# Debug Event Router

This block sits beside a processor core's exception logic and decides, every cycle, whether a debug-related condition starts a debug exception, starts a panic, or does nothing. Its inputs are four synchronous debug requests (instruction-address breakpoint, instruction-value breakpoint, operand-address watchpoint, software break), a step condition formed from the instruction-retire strobe, and a level-sensitive debug interrupt line. It also owns the live status register, its saved copy, the event-code register and the previous-event-code register.

While the status register's block bit is clear, a synchronous request launches a debug exception. While that bit is set, the same request becomes a panic. The panic still records the real event type, and the event code held before it is kept in the previous-event-code register. A debug interrupt is only taken with the block bit clear. It is never queued: if its line falls while the core is blocked, it is gone. Every launch saves the status register and then sets the block bit and clears the step bit. An exception-return strobe restores the saved copy.

Top module: `dbg_event_router`

## Requirements
- R1: Event codes are 12 bits wide. Instruction-address breakpoint is 0x000, instruction-value breakpoint is 0x020, operand watchpoint is 0x040, single-step is 0x060, software break is 0x080 and debug interrupt is 0x0A0.
- R2: With the block bit (status bit 28) at 0, a synchronous request in cycle t sets dbgLaunch high for cycle t+1 only. In the same cycle the event code takes the event's code and the previous-event code is left unchanged.
- R3: With the block bit at 1, the same request sets panicLaunch high instead of dbgLaunch, and the event code still takes the original event's code.
- R4: On a panic, the previous-event-code register takes the event code that was held before the panic.
- R5: When several events arrive in the same cycle, the winner is chosen in this order: instruction-address, instruction-value, software break, operand watchpoint, single-step, debug interrupt.
- R6: With the step bit (status bit 27) at 1, a retire strobe raises a single-step event: a debug exception when the block bit is 0 and a panic when it is 1. With the step bit at 0, a retire strobe raises nothing.
- R7: A high debug interrupt line is taken as a debug exception with code 0x0A0 only in a cycle where the block bit is 0 and no synchronous event is present. While the block bit is 1 the interrupt waits, and it is taken once the block bit is 0 if the line is still high.
- R8: If the debug interrupt line falls while the block bit is 1, that interrupt is never taken.
- R9: Every launch copies the whole status register into the saved status register, including the MMU-enable bit (bit 31). It then sets the block bit to 1 and clears the step bit in the live status register.
- R10: An exception-return strobe copies the saved status register into the live one. If a launch occurs in the same cycle, the launch takes priority. The srLoad write has the lowest priority of all status updates.
- R11: dbgLaunch and panicLaunch are single-cycle pulses and are never high together.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqIaddr | input | 1 | Instruction-address breakpoint request |
| reqIval | input | 1 | Instruction-value breakpoint request |
| reqOaddr | input | 1 | Operand-address watchpoint request |
| reqBreak | input | 1 | Software break request |
| retire | input | 1 | Instruction-retire strobe |
| dbgIntLine | input | 1 | Level-sensitive debug interrupt |
| rteStrobe | input | 1 | Exception-return strobe |
| srLoad | input | 1 | Write the live status register from the core |
| srLoadData | input | 32 | Status value for srLoad |
| dbgLaunch | output | 1 | Debug exception launch pulse |
| panicLaunch | output | 1 | Panic launch pulse |
| expEvt | output | 12 | Event-code register |
| pexpEvt | output | 12 | Previous-event-code register |
| srOut | output | 32 | Live status register |
| ssrOut | output | 32 | Saved status register |

## Verification
The bench builds the block with its default parameters: a 32-bit status register with the block bit at 28 and the step bit at 27, plus the MMU-enable bit at 31 carried as plain data. With these values every routing case can be reached directly. The bench sets the block and step bits through srLoad, so it can drive panics, held and lost interrupts, and step events under both block states. Since bit 31 lies outside both control bits, it also shows that the save and restore copy the whole register, not only the bits the router alters.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int EVT_W    = 12;
  localparam int NUM_SYNC = 5;

  typedef logic [EVT_W-1:0] evt_code_t;

  localparam evt_code_t CODE_IADDR = 12'h000;
  localparam evt_code_t CODE_IVAL  = 12'h020;
  localparam evt_code_t CODE_OADDR = 12'h040;
  localparam evt_code_t CODE_STEP  = 12'h060;
  localparam evt_code_t CODE_BREAK = 12'h080;
  localparam evt_code_t CODE_INT   = 12'h0A0;

  // Strobes from control to datapath
  typedef struct packed {
    logic      launchDbg;
    logic      launchPanic;
    logic      restore;
    logic      load;
    evt_code_t code;
  } dp_strobe_t;

  // Synchronous sources by rank, index 0 is the highest priority
  function automatic evt_code_t rankCode(int idx);
    case (idx)
      0:       rankCode = CODE_IADDR;
      1:       rankCode = CODE_IVAL;
      2:       rankCode = CODE_BREAK;
      3:       rankCode = CODE_OADDR;
      default: rankCode = CODE_STEP;
    endcase
  endfunction
endpackage

// File: rtl/dbg_evt_ctrl.sv
module dbg_evt_ctrl
  import dbg_evt_pkg::*;
(
  input  logic       reqIaddr,
  input  logic       reqIval,
  input  logic       reqOaddr,
  input  logic       reqBreak,
  input  logic       retire,
  input  logic       dbgIntLine,
  input  logic       rteStrobe,
  input  logic       srLoad,
  input  logic       srBl,
  input  logic       srStep,
  output dp_strobe_t strobe
);
  logic [NUM_SYNC-1:0] syncVec;
  logic                syncHit;
  evt_code_t           syncCode;
  logic                intTake;
  logic                anyLaunch;

  assign syncVec = {retire & srStep, reqOaddr, reqBreak, reqIval, reqIaddr};

  // Walk from lowest rank upward so the highest-ranked request wins
  always_comb begin
    syncHit  = 1'b0;
    syncCode = CODE_STEP;
    for (int i = NUM_SYNC - 1; i >= 0; i--) begin
      if (syncVec[i]) begin
        syncHit  = 1'b1;
        syncCode = rankCode(i);
      end
    end
  end

  // Interrupt is sampled as a level; nothing is latched while blocked
  assign intTake   = dbgIntLine && !srBl && !syncHit;
  assign anyLaunch = syncHit || intTake;

  always_comb begin
    strobe.launchDbg   = (syncHit && !srBl) || intTake;
    strobe.launchPanic = syncHit && srBl;
    strobe.code        = syncHit ? syncCode : CODE_INT;
    strobe.restore     = rteStrobe && !anyLaunch;
    strobe.load        = srLoad && !anyLaunch && !rteStrobe;
  end
endmodule

// File: rtl/dbg_evt_dpath.sv
module dbg_evt_dpath
  import dbg_evt_pkg::*;
#(
  parameter int              SR_W     = 32,
  parameter int              BL_POS   = 28,
  parameter int              STEP_POS = 27,
  parameter logic [SR_W-1:0] SR_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dp_strobe_t      strobe,
  input  logic [SR_W-1:0] srLoadData,
  output logic [SR_W-1:0] sr,
  output logic [SR_W-1:0] ssr,
  output evt_code_t       expEvt,
  output evt_code_t       pexpEvt,
  output logic            dbgLaunch,
  output logic            panicLaunch
);
  logic            launch;
  logic [SR_W-1:0] srLaunch;

  assign launch = strobe.launchDbg || strobe.launchPanic;

  always_comb begin
    srLaunch           = sr;
    srLaunch[BL_POS]   = 1'b1;
    srLaunch[STEP_POS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr          <= SR_RESET;
      ssr         <= '0;
      expEvt      <= '0;
      pexpEvt     <= '0;
      dbgLaunch   <= 1'b0;
      panicLaunch <= 1'b0;
    end else begin
      dbgLaunch   <= strobe.launchDbg;
      panicLaunch <= strobe.launchPanic;
      if (launch) begin
        ssr    <= sr;
        sr     <= srLaunch;
        expEvt <= strobe.code;
        if (strobe.launchPanic) pexpEvt <= expEvt;
      end else if (strobe.restore) begin
        sr <= ssr;
      end else if (strobe.load) begin
        sr <= srLoadData;
      end
    end
  end

  // R3: a panic only follows a cycle in which the block bit was set
  a_r3_panic_only_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    panicLaunch |-> $past(sr[BL_POS]));

  // R4: previous code holds what the event code held before the panic
  a_r4_prev_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    panicLaunch |-> pexpEvt == $past(expEvt));

  // R7: an interrupt launch only follows an unblocked cycle
  a_r7_int_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgLaunch && expEvt == CODE_INT) |-> !$past(sr[BL_POS]));

  // R9: status is saved whole, and the live copy is blocked and unstepped
  a_r9_ssr_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgLaunch || panicLaunch) |-> ssr == $past(sr));

  a_r9_block_set: assert property (@(posedge clk) disable iff (!rst_n)
    (dbgLaunch || panicLaunch) |-> (sr[BL_POS] && !sr[STEP_POS]));

  // R11: exclusive single-cycle pulses
  a_r11_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbgLaunch && panicLaunch));

  a_r11_dbg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbgLaunch |=> !dbgLaunch);
endmodule

// File: rtl/dbg_event_router.sv
module dbg_event_router
  import dbg_evt_pkg::*;
#(
  parameter int              SR_W     = 32,
  parameter int              BL_POS   = 28,
  parameter int              STEP_POS = 27,
  parameter logic [SR_W-1:0] SR_RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqIaddr,
  input  logic             reqIval,
  input  logic             reqOaddr,
  input  logic             reqBreak,
  input  logic             retire,
  input  logic             dbgIntLine,
  input  logic             rteStrobe,
  input  logic             srLoad,
  input  logic [SR_W-1:0]  srLoadData,
  output logic             dbgLaunch,
  output logic             panicLaunch,
  output logic [EVT_W-1:0] expEvt,
  output logic [EVT_W-1:0] pexpEvt,
  output logic [SR_W-1:0]  srOut,
  output logic [SR_W-1:0]  ssrOut
);
  dp_strobe_t strobe;

  dbg_evt_ctrl i_ctrl (
    .reqIaddr   (reqIaddr),
    .reqIval    (reqIval),
    .reqOaddr   (reqOaddr),
    .reqBreak   (reqBreak),
    .retire     (retire),
    .dbgIntLine (dbgIntLine),
    .rteStrobe  (rteStrobe),
    .srLoad     (srLoad),
    .srBl       (srOut[BL_POS]),
    .srStep     (srOut[STEP_POS]),
    .strobe     (strobe)
  );

  dbg_evt_dpath #(
    .SR_W     (SR_W),
    .BL_POS   (BL_POS),
    .STEP_POS (STEP_POS),
    .SR_RESET (SR_RESET)
  ) i_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .srLoadData  (srLoadData),
    .sr          (srOut),
    .ssr         (ssrOut),
    .expEvt      (expEvt),
    .pexpEvt     (pexpEvt),
    .dbgLaunch   (dbgLaunch),
    .panicLaunch (panicLaunch)
  );
endmodule

// File: tb/test_dbg_event_router.sv
module test_dbg_event_router;
  localparam logic [31:0] BL   = 32'h1000_0000;
  localparam logic [31:0] STEP = 32'h0800_0000;
  localparam logic [31:0] MMU  = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqIaddr = 0, reqIval = 0, reqOaddr = 0, reqBreak = 0;
  logic retire = 0, dbgIntLine = 0, rteStrobe = 0, srLoad = 0;
  logic [31:0] srLoadData = '0;
  logic dbgLaunch, panicLaunch;
  logic [11:0] expEvt, pexpEvt;
  logic [31:0] srOut, ssrOut;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dbg_event_router i_dbg_event_router (
    .clk(clk), .rst_n(rst_n), .reqIaddr(reqIaddr), .reqIval(reqIval),
    .reqOaddr(reqOaddr), .reqBreak(reqBreak), .retire(retire),
    .dbgIntLine(dbgIntLine), .rteStrobe(rteStrobe), .srLoad(srLoad),
    .srLoadData(srLoadData), .dbgLaunch(dbgLaunch), .panicLaunch(panicLaunch),
    .expEvt(expEvt), .pexpEvt(pexpEvt), .srOut(srOut), .ssrOut(ssrOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: inputs set before the call take effect, then one-shots drop
  task automatic adv();
    @(negedge clk);
    reqIaddr = 0; reqIval = 0; reqOaddr = 0; reqBreak = 0;
    retire = 0; rteStrobe = 0; srLoad = 0;
  endtask

  task automatic loadSr(logic [31:0] v);
    srLoad = 1; srLoadData = v; adv();
  endtask

  task automatic t_reset();
    check("R12 dbgLaunch", dbgLaunch, 0);
    check("R12 panicLaunch", panicLaunch, 0);
    check("R12 expEvt", expEvt, 0);
    check("R12 pexpEvt", pexpEvt, 0);
    check("R12 sr", srOut, 0);
    check("R12 ssr", ssrOut, 0);
  endtask

  task automatic t_debug_basic();
    loadSr(32'h0000_0005);
    reqIval = 1; adv();
    check("R2 dbgLaunch", dbgLaunch, 1);
    check("R2 no panic", panicLaunch, 0);
    check("R1 ival code", expEvt, 12'h020);
    check("R2 pexp unchanged", pexpEvt, 0);
    check("R9 ssr saved", ssrOut, 32'h0000_0005);
    check("R9 sr blocked", srOut, 32'h0000_0005 | BL);
    adv();
    check("R11 pulse ends", dbgLaunch, 0);
    rteStrobe = 1; adv();
    check("R10 rte restores", srOut, 32'h0000_0005);
  endtask

  task automatic t_panic();
    loadSr(BL);
    reqOaddr = 1; adv();
    check("R3 panicLaunch", panicLaunch, 1);
    check("R3 no dbg", dbgLaunch, 0);
    check("R3 original code", expEvt, 12'h040);
    check("R4 previous code", pexpEvt, 12'h020);
    adv();
    check("R11 panic pulse ends", panicLaunch, 0);
    reqBreak = 1; adv();
    check("R3 break panic", panicLaunch, 1);
    check("R1 break code", expEvt, 12'h080);
    check("R4 previous code 2", pexpEvt, 12'h040);
  endtask

  task automatic t_priority();
    loadSr(STEP);
    reqIaddr = 1; reqIval = 1; reqBreak = 1; reqOaddr = 1; retire = 1; adv();
    check("R5 iaddr wins", expEvt, 12'h000);
    check("R5 single launch", dbgLaunch, 1);
    loadSr(STEP);
    reqIval = 1; reqBreak = 1; reqOaddr = 1; retire = 1; adv();
    check("R5 ival wins", expEvt, 12'h020);
    loadSr(STEP);
    reqBreak = 1; reqOaddr = 1; retire = 1; adv();
    check("R5 break over watch", expEvt, 12'h080);
    loadSr(STEP);
    reqOaddr = 1; retire = 1; adv();
    check("R5 watch over step", expEvt, 12'h040);
    loadSr(0);
    dbgIntLine = 1; reqBreak = 1; adv();
    dbgIntLine = 0;
    check("R5 sync over interrupt", expEvt, 12'h080);
  endtask

  task automatic t_step();
    loadSr(STEP);
    retire = 1; adv();
    check("R6 step dbg", dbgLaunch, 1);
    check("R1 step code", expEvt, 12'h060);
    check("R9 step cleared", srOut, BL);
    loadSr(STEP | BL);
    retire = 1; adv();
    check("R6 step panic", panicLaunch, 1);
    check("R6 step panic code", expEvt, 12'h060);
    loadSr(0);
    reqIaddr = 1; adv();
    loadSr(0);
    retire = 1; adv();
    check("R6 no step dbg", dbgLaunch, 0);
    check("R6 no step panic", panicLaunch, 0);
    check("R6 code untouched", expEvt, 12'h000);
  endtask

  task automatic t_int_held();
    loadSr(BL);
    dbgIntLine = 1;
    adv(); adv(); adv();
    check("R7 blocked no launch", dbgLaunch, 0);
    check("R7 blocked code", expEvt, 12'h000);
    loadSr(0);
    check("R7 not yet", dbgLaunch, 0);
    adv();
    dbgIntLine = 0;
    check("R7 taken after unblock", dbgLaunch, 1);
    check("R1 interrupt code", expEvt, 12'h0A0);
  endtask

  task automatic t_int_lost();
    loadSr(BL);
    dbgIntLine = 1; adv(); adv();
    dbgIntLine = 0; adv();
    loadSr(0);
    adv();
    check("R8 lost dbg", dbgLaunch, 0);
    adv();
    check("R8 lost dbg later", dbgLaunch, 0);
    check("R8 code kept", expEvt, 12'h0A0);
    check("R8 sr unblocked", srOut, 0);
  endtask

  task automatic t_mmu_and_collide();
    loadSr(MMU | STEP);
    reqIaddr = 1; rteStrobe = 1; adv();
    check("R10 launch beats rte", dbgLaunch, 1);
    check("R9 mmu saved", ssrOut, MMU | STEP);
    check("R10 sr after collide", srOut, MMU | BL);
    rteStrobe = 1; srLoad = 1; srLoadData = 32'h1234; adv();
    check("R10 rte over load", srOut, MMU | STEP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    adv();
    t_debug_basic();
    t_panic();
    t_priority();
    t_step();
    t_int_held();
    t_int_lost();
    t_mmu_and_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule